// File: doc/BRIEF.md
# Flash Bus Interface Latch Unit

This unit is a clocked front end for a byte-wide memory bus that is controlled by three active-low strobes: chip select, output enable and write enable. It passes the strobes through a two-stage synchronizer and works out which bus mode is present: standby, output disabled, read or write. It reports that mode on a small status output.

A write cycle can be timed by either strobe. When chip select is already low, write enable can act as the timing strobe. When write enable is already low, chip select can act as the timing strobe. Both cases reduce to one combined strobe, which is the logical OR of the two active-low inputs. The address is taken when that strobe falls and the data byte is taken when it rises. The finished write comes out as a one-cycle pulse together with the captured address and byte. The same write also lands in a small internal byte store, at the address taken modulo the store depth.

Reads return one of two things, chosen by a separate identification select input. With the select low, a read returns the contents of the store. With the select high, a read returns one of two fixed identification bytes, chosen by address bits 0, 1 and 6. The data-drive enable is registered, and it is high only while a read is decoded.

Top module: `flash_bus_front`

## Requirements
- R1: After reset, `mode_o` is 0, `dat_oe_o` is 0, `dat_o` is 0x00 and `wr_pulse_o` is 0.
- R2: `mode_o` follows the strobes three clock edges after they settle, with these encodings:
  - 0 (standby) when chip select is high, whatever the other two strobes are.
  - 1 (output disabled) when chip select is low and the other two strobes are high, and also when all three strobes are low.
  - 2 (read) when chip select and output enable are low and write enable is high.
  - 3 (write) when chip select and write enable are low and output enable is high.
- R3: `dat_oe_o` is 1 only while the mode is read. Whenever `dat_oe_o` is 0, `dat_o` is 0x00.
- R4: In a cycle timed by write enable, with chip select low and output enable high:
  - the address on `addr_i` at the falling edge of write enable appears on `wr_addr_o`;
  - the byte on `dat_i` at the rising edge of write enable appears on `wr_data_o`;
  - both appear together with `wr_pulse_o`.
- R5: In a cycle timed by chip select, with write enable held low and output enable high:
  - the address is taken at the falling edge of chip select;
  - the byte is taken at the rising edge of chip select;
  - the result is reported in the same way as in R4.
- R6: If output enable is low when the combined strobe falls, no write pulse is issued and the store is left unchanged.
- R7: Address changes after the falling edge of the combined strobe have no effect on the captured address. Data values present before the rising edge have no effect on the captured byte.
- R8: Each completed write stores its byte at index `wr_addr_o mod DEPTH`, where DEPTH is 16 by default. A read with `sig_mode_i` low returns the stored byte at index `addr_i mod DEPTH`. Stored bytes reset to 0x00.
- R9: With `sig_mode_i` high, a read with address bits 0, 1 and 6 all low returns 0x20. All other address bits are ignored.
- R10: With `sig_mode_i` high, a read with bit 0 high and bits 1 and 6 low returns 0xE2. All other address bits are ignored.
- R11: With `sig_mode_i` high, any other combination of address bits 0, 1 and 6 reads as 0x00.
- R12: `wr_pulse_o` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n_i | input | 1 | Chip select strobe, active low, asynchronous |
| oe_n_i | input | 1 | Output enable strobe, active low, asynchronous |
| we_n_i | input | 1 | Write enable strobe, active low, asynchronous |
| addr_i | input | 19 | Bus address |
| dat_i | input | 8 | Bus write data |
| sig_mode_i | input | 1 | 1 selects the identification bytes for reads |
| dat_o | output | 8 | Registered read data, 0x00 when not driving |
| dat_oe_o | output | 1 | Data bus drive enable |
| mode_o | output | 2 | Decoded bus mode (0 standby, 1 output disabled, 2 read, 3 write) |
| wr_pulse_o | output | 1 | One-cycle pulse for each completed write |
| wr_addr_o | output | 19 | Address captured for the last write |
| wr_data_o | output | 8 | Byte captured for the last write |

## Verification
A wrong value in the synchronizer or in the stored previous strobe level shows up in two ways. A write pulse may be missing or extra, which the scoreboard sees on the very cycle it should have appeared. Or `mode_o` may sit on the wrong code three edges after the strobes move. A wrong armed flag or a wrong address latch does not show at the moment it happens. It surfaces at the end of that write cycle, as a pulse or an address that does not match. A corrupted store entry stays hidden until that index is read back, which can be many cycles later. For that reason the bench reads back every written index, including one reached through aliasing.

// File: rtl/fbf_pkg.sv
`timescale 1ns/1ps
package fbf_pkg;

    // Decoded bus mode, reported on the mode output.
    typedef enum logic [1:0] {
        FBF_STANDBY = 2'd0,
        FBF_OUT_OFF = 2'd1,
        FBF_READ    = 2'd2,
        FBF_WRITE   = 2'd3
    } fbf_mode_e;

    // Selects an identification byte from key = {a6, a1, a0}.
    function automatic logic [7:0] fbf_sig_byte(
        input logic [2:0] key,
        input logic [7:0] mfr,
        input logic [7:0] dev
    );
        logic [7:0] r;
        case (key)
            3'b000:  r = mfr;
            3'b001:  r = dev;
            default: r = 8'h00;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/fbf_sync.sv
`timescale 1ns/1ps
module fbf_sync #(
    parameter int          W       = 3,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < W; i++) begin
            st_d.s1[i] = async_i[i];
            st_d.s2[i] = st_q.s1[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.s1 <= RST_VAL;
            st_q.s2 <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.s2;
endmodule

// File: rtl/fbf_decode.sv
`timescale 1ns/1ps
module fbf_decode
    import fbf_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cs_s_i,
    input  logic      oe_s_i,
    input  logic      we_s_i,
    output logic      read_now_o,
    output fbf_mode_e mode_o
);
    typedef struct packed {
        fbf_mode_e mode;
    } dec_st_t;

    dec_st_t   st_d, st_q;
    fbf_mode_e mode_now;

    always_comb begin
        if (cs_s_i)                mode_now = FBF_STANDBY;
        else if (!oe_s_i && we_s_i) mode_now = FBF_READ;
        else if (oe_s_i && !we_s_i) mode_now = FBF_WRITE;
        else                       mode_now = FBF_OUT_OFF;
        st_d      = st_q;
        st_d.mode = mode_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.mode <= FBF_STANDBY;
        else        st_q      <= st_d;
    end

    assign read_now_o = (mode_now == FBF_READ);
    assign mode_o     = st_q.mode;

    // A deselected bus must report standby on the next cycle.
    p_standby_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s_i |=> (st_q.mode == FBF_STANDBY));
endmodule

// File: rtl/fbf_wr_capture.sv
`timescale 1ns/1ps
module fbf_wr_capture #(
    parameter int AW = 19,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_s_i,
    input  logic          oe_s_i,
    input  logic          we_s_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] dat_i,
    output logic          pulse_o,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] data_o
);
    typedef struct packed {
        logic          prev;
        logic          armed;
        logic          pulse;
        logic [AW-1:0] addr_lat;
        logic [DW-1:0] data_lat;
    } cap_st_t;

    cap_st_t st_d, st_q;
    logic    strobe, fall, rise;

    always_comb begin
        // Combined active-low strobe: low only while both selects are low.
        strobe     = cs_s_i | we_s_i;
        fall       = st_q.prev & ~strobe;
        rise       = ~st_q.prev & strobe;
        st_d       = st_q;
        st_d.prev  = strobe;
        st_d.pulse = 1'b0;
        if (fall && oe_s_i) begin
            st_d.armed    = 1'b1;
            st_d.addr_lat = addr_i;
        end
        if (rise) begin
            st_d.armed = 1'b0;
            if (st_q.armed) begin
                st_d.data_lat = dat_i;
                st_d.pulse    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.prev     <= 1'b1;
            st_q.armed    <= 1'b0;
            st_q.pulse    <= 1'b0;
            st_q.addr_lat <= '0;
            st_q.data_lat <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse_o = st_q.pulse;
    assign addr_o  = st_q.addr_lat;
    assign data_o  = st_q.data_lat;

    p_pulse_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pulse |=> !st_q.pulse);
    p_pulse_armed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pulse |-> $past(st_q.armed));
    p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.armed && $past(st_q.armed)) |-> $stable(st_q.addr_lat));
endmodule

// File: rtl/fbf_store.sv
`timescale 1ns/1ps
module fbf_store
    import fbf_pkg::*;
#(
    parameter int         DW     = 8,
    parameter int         DEPTH  = 16,
    parameter logic [7:0] MFR_ID = 8'h20,
    parameter logic [7:0] DEV_ID = 8'hE2,
    localparam int        IW     = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          read_now_i,
    input  logic          sig_mode_i,
    input  logic [2:0]    sig_key_i,
    input  logic [IW-1:0] rd_idx_i,
    input  logic          wr_en_i,
    input  logic [IW-1:0] wr_idx_i,
    input  logic [DW-1:0] wr_dat_i,
    output logic [DW-1:0] dat_o,
    output logic          dat_oe_o
);
    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [DW-1:0]            dat;
        logic                     oe;
    } sto_st_t;

    sto_st_t       st_d, st_q;
    logic [DW-1:0] rd_val;

    always_comb begin
        st_d = st_q;
        if (wr_en_i) st_d.mem[wr_idx_i] = wr_dat_i;
        if (sig_mode_i) rd_val = DW'(fbf_sig_byte(sig_key_i, MFR_ID, DEV_ID));
        else            rd_val = st_q.mem[rd_idx_i];
        st_d.oe  = read_now_i;
        st_d.dat = read_now_i ? rd_val : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dat_o    = st_q.dat;
    assign dat_oe_o = st_q.oe;

    p_mem_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (st_q.mem[$past(wr_idx_i)] == $past(wr_dat_i)));
endmodule

// File: rtl/flash_bus_front.sv
`timescale 1ns/1ps
module flash_bus_front
    import fbf_pkg::*;
#(
    parameter int         AW     = 19,
    parameter int         DW     = 8,
    parameter int         DEPTH  = 16,
    parameter logic [7:0] MFR_ID = 8'h20,
    parameter logic [7:0] DEV_ID = 8'hE2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n_i,
    input  logic          oe_n_i,
    input  logic          we_n_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] dat_i,
    input  logic          sig_mode_i,
    output logic [DW-1:0] dat_o,
    output logic          dat_oe_o,
    output logic [1:0]    mode_o,
    output logic          wr_pulse_o,
    output logic [AW-1:0] wr_addr_o,
    output logic [DW-1:0] wr_data_o
);
    localparam int IW = $clog2(DEPTH);

    logic [2:0] strb_s;
    logic       read_now;
    fbf_mode_e  mode;

    fbf_sync #(.W(3), .RST_VAL(3'b111)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({cs_n_i, oe_n_i, we_n_i}),
        .sync_o  (strb_s)
    );

    fbf_decode u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_s_i     (strb_s[2]),
        .oe_s_i     (strb_s[1]),
        .we_s_i     (strb_s[0]),
        .read_now_o (read_now),
        .mode_o     (mode)
    );

    fbf_wr_capture #(.AW(AW), .DW(DW)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_s_i  (strb_s[2]),
        .oe_s_i  (strb_s[1]),
        .we_s_i  (strb_s[0]),
        .addr_i  (addr_i),
        .dat_i   (dat_i),
        .pulse_o (wr_pulse_o),
        .addr_o  (wr_addr_o),
        .data_o  (wr_data_o)
    );

    fbf_store #(.DW(DW), .DEPTH(DEPTH), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_sto (
        .clk        (clk),
        .rst_n      (rst_n),
        .read_now_i (read_now),
        .sig_mode_i (sig_mode_i),
        .sig_key_i  ({addr_i[6], addr_i[1], addr_i[0]}),
        .rd_idx_i   (addr_i[IW-1:0]),
        .wr_en_i    (wr_pulse_o),
        .wr_idx_i   (wr_addr_o[IW-1:0]),
        .wr_dat_i   (wr_data_o),
        .dat_o      (dat_o),
        .dat_oe_o   (dat_oe_o)
    );

    assign mode_o = mode;

    p_oe_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dat_oe_o |-> (mode_o == 2'd2));
endmodule

// File: tb/sim_flash_bus_front.sv
`timescale 1ns/1ps
module sim_flash_bus_front;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [18:0] addr = '0;
    logic [7:0]  din = '0;
    logic        sig = 1'b0;
    logic [7:0]  dat_o;
    logic        dat_oe;
    logic [1:0]  mode;
    logic        wr_pulse;
    logic [18:0] wr_addr;
    logic [7:0]  wr_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;
    bit mon_on   = 0;

    logic [18:0] qa[$];
    logic [7:0]  qd[$];
    string       qr[$];

    always #2.5 clk = ~clk;

    flash_bus_front u0 (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .oe_n_i(oe_n), .we_n_i(we_n),
        .addr_i(addr), .dat_i(din), .sig_mode_i(sig), .dat_o(dat_o),
        .dat_oe_o(dat_oe), .mode_o(mode), .wr_pulse_o(wr_pulse),
        .wr_addr_o(wr_addr), .wr_data_o(wr_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Scoreboard monitor: pops one expected write per pulse.
    logic prev_pulse = 1'b0;
    always @(negedge clk) begin
        if (mon_on) begin
            if (wr_pulse) begin
                check("R12 pulse width", {31'd0, prev_pulse}, 32'd0);
                if (qa.size() == 0) begin
                    check("R6 unexpected write pulse", 32'd1, 32'd0);
                end else begin
                    logic [18:0] ea;
                    logic [7:0]  ed;
                    string       er;
                    ea = qa.pop_front();
                    ed = qd.pop_front();
                    er = qr.pop_front();
                    check({er, " R7 address"}, {13'd0, wr_addr}, {13'd0, ea});
                    check({er, " R7 data"}, {24'd0, wr_data}, {24'd0, ed});
                end
            end
            prev_pulse = wr_pulse;
        end
    end

    task automatic we_write(input logic [18:0] a, input logic [7:0] d);
        cs_n = 0; oe_n = 1; we_n = 1; addr = a; din = ~d;
        wait_n(4);
        we_n = 0;
        wait_n(4);
        check("R2 write mode (we timed)", {30'd0, mode}, 32'd3);
        addr = ~a;
        din  = d;
        qa.push_back(a); qd.push_back(d); qr.push_back("R4");
        wait_n(2);
        we_n = 1;
        wait_n(5);
        cs_n = 1;
        wait_n(4);
    endtask

    task automatic ce_write(input logic [18:0] a, input logic [7:0] d);
        cs_n = 1; oe_n = 1; we_n = 0; addr = a; din = ~d;
        wait_n(4);
        cs_n = 0;
        wait_n(4);
        check("R2 write mode (cs timed)", {30'd0, mode}, 32'd3);
        addr = ~a;
        din  = d;
        qa.push_back(a); qd.push_back(d); qr.push_back("R5");
        wait_n(2);
        cs_n = 1;
        wait_n(5);
        we_n = 1;
        wait_n(4);
    endtask

    task automatic blocked_write(input logic [18:0] a, input logic [7:0] d);
        cs_n = 0; oe_n = 0; we_n = 1; addr = a; din = d;
        wait_n(4);
        we_n = 0;
        wait_n(4);
        check("R2 all strobes low", {30'd0, mode}, 32'd1);
        check("R3 no drive all low", {31'd0, dat_oe}, 32'd0);
        we_n = 1;
        wait_n(5);
        cs_n = 1; oe_n = 1;
        wait_n(4);
    endtask

    task automatic do_read(input string req, input logic [18:0] a, input logic s,
                           input logic [7:0] exp);
        sig = s; addr = a; cs_n = 0; oe_n = 0; we_n = 1;
        wait_n(4);
        check({req, " mode"}, {30'd0, mode}, 32'd2);
        check({req, " R3 drive"}, {31'd0, dat_oe}, 32'd1);
        check({req, " data"}, {24'd0, dat_o}, {24'd0, exp});
        oe_n = 1;
        wait_n(4);
        check("R3 drive off", {31'd0, dat_oe}, 32'd0);
        check("R3 data quiet", {24'd0, dat_o}, 32'd0);
        cs_n = 1; sig = 0;
        wait_n(4);
    endtask

    initial begin
        wait_n(3);
        check("R1 mode", {30'd0, mode}, 32'd0);
        check("R1 drive", {31'd0, dat_oe}, 32'd0);
        check("R1 data", {24'd0, dat_o}, 32'd0);
        check("R1 pulse", {31'd0, wr_pulse}, 32'd0);
        rst_n = 1;
        mon_on = 1;
        wait_n(4);

        // R2/R3: output disabled and standby
        cs_n = 0; oe_n = 1; we_n = 1;
        wait_n(4);
        check("R2 output disabled", {30'd0, mode}, 32'd1);
        check("R3 no drive disabled", {31'd0, dat_oe}, 32'd0);
        cs_n = 1; oe_n = 0;
        wait_n(4);
        check("R2 standby", {30'd0, mode}, 32'd0);
        check("R3 no drive standby", {31'd0, dat_oe}, 32'd0);
        check("R3 data quiet standby", {24'd0, dat_o}, 32'd0);
        oe_n = 1;
        wait_n(4);

        // Writes under both timing strobes
        we_write(19'h12345, 8'hA7);
        ce_write(19'h6000A, 8'h3C);
        we_write(19'h00013, 8'h5A);
        ce_write(19'h7FFF1, 8'hC4);
        blocked_write(19'h00007, 8'hFF);
        wait_n(4);
        check("R4 R5 all expected pulses seen", qa.size(), 32'd0);

        // R8 store read back, including aliasing
        do_read("R8 idx5", 19'h00005, 1'b0, 8'hA7);
        do_read("R8 idx10", 19'h7000A, 1'b0, 8'h3C);
        do_read("R8 alias idx3", 19'h00003, 1'b0, 8'h5A);
        do_read("R8 idx1", 19'h00021, 1'b0, 8'hC4);
        do_read("R6 blocked idx7", 19'h00007, 1'b0, 8'h00);

        // Identification bytes
        do_read("R9 zero addr", 19'h00000, 1'b1, 8'h20);
        do_read("R9 upper bits set", 19'h7FFBC, 1'b1, 8'h20);
        do_read("R10 low addr", 19'h00001, 1'b1, 8'hE2);
        do_read("R10 upper bits set", 19'h7FFBD, 1'b1, 8'hE2);
        do_read("R11 a1", 19'h00002, 1'b1, 8'h00);
        do_read("R11 a6", 19'h00040, 1'b1, 8'h00);
        do_read("R11 a6 a1 a0", 19'h00043, 1'b1, 8'h00);

        wait_n(4);
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule